// File: doc/BRIEF.md
# Dual-Lane Sync-Framed Deserializer

This block rebuilds 16-bit words from two serial data lanes that travel together with a forwarded clock and an active-low framing pulse. Every rising clock edge, each lane's current bit is pushed into that lane's own shift register. The framing pulse is low for one cycle out of every eight. It marks the cycle in which the last bit of a word is on the lanes.

When the block samples the pulse low, it copies both freshly completed bytes into a parallel output register and raises a one-cycle valid strobe. The first pulse after reset only sets the framing phase and produces no word.

From then on, the block times every pulse against the one before it. A pulse that does not come exactly eight cycles after its predecessor raises a sticky framing-error flag. The block uses no internal bit counter and no alignment pattern: the framing pulse alone defines word boundaries.

Top module: `dual_lane_deser`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `word_o` is zero, `word_vld_o` is 0 and `frame_err_o` is 0.
- R2: Lane A bits arrive least significant first. Bit k of `word_o[7:0]` is the lane A bit sampled k cycles after the start of the word, so the bit sampled in the pulse cycle lands in bit 7.
- R3: Lane B fills `word_o[15:8]` with the same bit order, independently of lane A.
- R4: A rising edge that samples `sync_n_i` low, once the block is armed, loads `word_o` and sets `word_vld_o` at that same edge. The loaded value includes the lane bits sampled at that edge.
- R5: `word_vld_o` is high only in the cycle that follows a capture edge. `word_o` keeps its value at every other edge.
- R6: The first low sample of `sync_n_i` after reset leaves `word_o` unchanged and `word_vld_o` low; it only arms the block.
- R7: Once armed, a low sample of `sync_n_i` that comes a number of cycles other than 8 after the previous low sample sets `frame_err_o` at that edge. Gaps longer than 8, including very long ones, also count as errors.
- R8: `frame_err_o` stays set until reset, whatever framing follows, and reset clears it.
- R9: A mistimed pulse still captures a word, using the last eight bits sampled on each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Forwarded clock, rising edge active |
| rst_n_i | input | 1 | Synchronous active-low reset |
| lane_a_i | input | 1 | Serial lane A, low byte of the word |
| lane_b_i | input | 1 | Serial lane B, high byte of the word |
| sync_n_i | input | 1 | Active-low framing pulse, low in the cycle of a word's last bit |
| word_o | output | 16 | Last captured word: lane B byte above lane A byte |
| word_vld_o | output | 1 | One-cycle strobe after each capture |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
Every result appears at the rising edge that samples the stimulus. This covers the shifted bits, the captured word, the valid strobe and the error flag.

The bench drives inputs at the falling edge and applies the same stimulus to its own reference model at the following rising edge. It then compares all outputs one time unit later. As a result, each comparison sees exactly the edge that was due, and the strobe is confirmed low again on the next edge.

Directed frames test arming, short and long gaps, back-to-back pulses and reset clearing. Randomly jittered frames then exercise the same paths.

// File: rtl/dual_lane_deser.sv
module dual_lane_deser #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  lane_a_i,
  input  logic                  lane_b_i,
  input  logic                  sync_n_i,
  output logic [2*BYTE_W-1:0]   word_o,
  output logic                  word_vld_o,
  output logic                  frame_err_o
);

  localparam int GAP_W = $clog2(BYTE_W) + 2;
  localparam logic [GAP_W-1:0] GAP_OK  = GAP_W'(BYTE_W);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [BYTE_W-1:0] sh_a, sh_b;
  logic [BYTE_W-1:0] nxt_a, nxt_b;
  logic [GAP_W-1:0]  gap;
  logic              armed;
  logic              sync_hit;

  assign sync_hit = ~sync_n_i;
  assign nxt_a    = {lane_a_i, sh_a[BYTE_W-1:1]};
  assign nxt_b    = {lane_b_i, sh_b[BYTE_W-1:1]};

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      sh_a        <= '0;
      sh_b        <= '0;
      gap         <= '0;
      armed       <= 1'b0;
      word_o      <= '0;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      sh_a       <= nxt_a;
      sh_b       <= nxt_b;
      word_vld_o <= sync_hit & armed;
      if (sync_hit) begin
        armed <= 1'b1;
        gap   <= GAP_W'(1);
        if (armed) begin
          word_o <= {nxt_b, nxt_a};
          if (gap != GAP_OK) frame_err_o <= 1'b1;
        end
      end else if (gap != GAP_MAX) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_err_o |=> frame_err_o);

  // R7
  err_on_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(frame_err_o) |-> $past(!sync_n_i));

  // R4
  vld_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    word_vld_o |-> $past(!sync_n_i));

  // R6
  vld_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    word_vld_o |-> armed);

  // R5
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !word_vld_o |-> $stable(word_o));

endmodule

// File: tb/dual_lane_deser_tb_top.sv
module dual_lane_deser_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        lane_a = 1'b0, lane_b = 1'b0, sync_n = 1'b1;
  logic [15:0] word;
  logic        vld, err;

  dual_lane_deser #(.BYTE_W(8)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .lane_a_i(lane_a), .lane_b_i(lane_b),
    .sync_n_i(sync_n), .word_o(word), .word_vld_o(vld), .frame_err_o(err)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0]  ma, mb;
  logic [15:0] ew;
  logic        ev, ee, marm;
  int          mgap;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    ma = '0; mb = '0; ew = '0; ev = 1'b0; ee = 1'b0; marm = 1'b0; mgap = 0;
  endfunction

  function automatic void model_edge(input logic la, input logic lb, input logic sn);
    ma = {la, ma[7:1]};
    mb = {lb, mb[7:1]};
    ev = !sn && marm;
    if (!sn) begin
      if (marm) begin
        ew = {mb, ma};
        if (mgap != 8) ee = 1'b1;
      end
      marm = 1'b1;
      mgap = 1;
    end else if (mgap < 31) begin
      mgap++;
    end
  endfunction

  task automatic step(input logic la, input logic lb, input logic sn);
    @(negedge clk);
    lane_a = la; lane_b = lb; sync_n = sn;
    @(posedge clk);
    model_edge(la, lb, sn);
    #1;
    chk(word == ew, "R2 word", word, ew);
    chk(vld == ev, "R5 valid", {15'd0, vld}, {15'd0, ev});
    chk(err == ee, "R8 error", {15'd0, err}, {15'd0, ee});
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] b, input int len);
    for (int i = 0; i < len; i++)
      step(a[(8-len+i) % 8], b[(8-len+i) % 8], (i == len-1) ? 1'b0 : 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sync_n = 1'b1;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    chk(word == 16'h0 && !vld && !err, "R1 in reset", {word[13:0], vld, err}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(word == 16'h0 && !vld && !err, "R1 after release", {word[13:0], vld, err}, 16'h0);
    model_edge(lane_a, lane_b, 1'b1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset();

    send(8'hFF, 8'hFF, 8);
    chk(!vld && word == 16'h0, "R6 first sync arms only", word, 16'h0);

    send(8'hA5, 8'h3C, 8);
    chk(word[7:0] == 8'hA5, "R2 lane A byte", {8'h0, word[7:0]}, 16'h00A5);
    chk(word[15:8] == 8'h3C, "R3 lane B byte", {8'h0, word[15:8]}, 16'h003C);
    chk(vld == 1'b1, "R4 valid at sync edge", {15'd0, vld}, 16'd1);

    send(8'h80, 8'h01, 8);
    chk(word == 16'h0180, "R4 last bit in MSB", word, 16'h0180);
    step(1'b0, 1'b0, 1'b1);
    chk(vld == 1'b0 && word == 16'h0180, "R5 strobe drops, word held", {word[14:0], vld}, {15'h0180, 1'b0});
    send(8'h5A, 8'hC3, 7);
    chk(err == 1'b0, "R7 exact gap no error", {15'd0, err}, 16'd0);

    send(8'h12, 8'h34, 7);
    chk(err == 1'b1, "R7 short gap", {15'd0, err}, 16'd1);
    chk(word == ew && vld, "R9 mistimed capture", word, ew);

    for (int k = 0; k < 4; k++) send(8'(k * 17), 8'(k * 29), 8);
    chk(err == 1'b1, "R8 sticky", {15'd0, err}, 16'd1);

    do_reset();
    chk(err == 1'b0, "R8 cleared by reset", {15'd0, err}, 16'd0);
    send(8'h00, 8'h00, 8);
    send(8'h11, 8'h22, 8);
    chk(err == 1'b0, "R7 good framing", {15'd0, err}, 16'd0);
    for (int i = 0; i < 19; i++) step(1'b1, 1'b0, 1'b1);
    send(8'h77, 8'h88, 1);
    chk(err == 1'b1, "R7 long gap", {15'd0, err}, 16'd1);

    do_reset();
    send(8'h00, 8'h00, 8);
    send(8'h00, 8'h00, 1);
    chk(err == 1'b1, "R7 back-to-back pulses", {15'd0, err}, 16'd1);

    do_reset();
    send(8'h00, 8'h00, 5);
    for (int n = 0; n < 400; n++) send(8'($urandom), 8'($urandom), 8);
    chk(err == 1'b0, "R7 random aligned run", {15'd0, err}, 16'd0);
    chk(word == ew, "R3 random word", word, ew);

    for (int n = 0; n < 300; n++) begin
      int len;
      len = ($urandom % 8 == 0) ? int'(6 + $urandom % 5) : 8;
      send(8'($urandom), 8'($urandom), len);
    end
    chk(err == ee, "R8 random jitter", {15'd0, err}, {15'd0, ee});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule